// File: doc/BRIEF.md
# Three-Stage Clock-Gated Handoff FIFO

This block moves a continuous stream of converter samples from the converter's clock into a reader clock of the same average rate but unknown phase. Three word-wide storage stages sit between the domains. A one-hot write ring opens exactly one stage per write clock through that stage's own clock enable. A separate one-hot read ring selects one stage into a registered output on every read clock.

There are no flags and no pointer exchange between the domains. Safe operation relies on two conditions. The reader consumes words at the writer's average rate. The two rings also start from different stages, so the stage being read is always one that was written at least a clock earlier and will not be written again for at least a clock. After both sides leave reset in the intended order, the output repeats the input stream with a fixed delay of one word.

Top module: `hof_handoff`

## Requirements
- R1: While `rd_rst_n` is low, `rd_data` is all zeros, and it clears as soon as `rd_rst_n` falls, without waiting for a clock. While `wr_rst_n` is low, all three stages hold zero.
- R2: The write ring leaves reset pointing at stage 0. Each rising `wr_clk` edge out of reset stores `wr_data` into the pointed stage and then moves the ring to the next stage, in the cyclic order 0, 1, 2, 0.
- R3: The read ring leaves reset pointing at stage 2, one stage behind the write ring. It advances one stage per rising `rd_clk` edge out of reset, in the same cyclic order 0, 1, 2, 0.
- R4: On every rising `rd_clk` edge out of reset, `rd_data` loads the stage that the read ring points at just before that edge.
- R5: Number the write and read edges after reset release from 0. If, at read edge j, between j and j+2 writes have completed, then read 0 returns zero and read j (j ≥ 1) returns the word taken at write j−1. This gives a constant one-word delay.
- R6: On any write clock edge, at most one stage changes, and a stage that changes is the one the write ring pointed at.
- R7: Every bit of the word passes through unchanged, including all-zeros, all-ones and alternating-bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Converter (write) clock |
| wr_rst_n | input | 1 | Active-low write-domain reset, asserted asynchronously, released on a write clock |
| wr_data | input | WIDTH | Sample word, taken on every write clock |
| rd_clk | input | 1 | Reader clock, same average rate as `wr_clk`, any phase |
| rd_rst_n | input | 1 | Active-low read-domain reset, asserted asynchronously, released on a read clock |
| rd_data | output | WIDTH | Registered output word, updated on every read clock |

## Verification
A read ring that starts on the wrong stage, or a write ring that skips or repeats a stage, shows up in the output stream within three read clocks of reset release. It appears as a zero or stale word where a fresh one was due, or as words in the wrong order. A stage that loads when its enable is off overwrites a word that has not been read yet, and that word is lost at the output two read clocks later. A bad output register or mux select corrupts the very next read. Sending distinct words through several full laps of the ring, with data patterns that toggle every bit, exposes each of these faults at the ports.

// File: rtl/hof_pkg.sv
package hof_pkg;

  // Storage depth of the handoff buffer (fixed at three words).
  localparam int HOF_DEPTH    = 3;
  // Reset positions of the two rings; the reader trails the writer by one stage.
  localparam int HOF_WR_START = 0;
  localparam int HOF_RD_START = (HOF_WR_START + HOF_DEPTH - 1) % HOF_DEPTH;

  typedef logic [HOF_DEPTH-1:0] hof_ring_t;

  // One-hot code with only bit 'pos' set.
  function automatic hof_ring_t hof_onehot(input int unsigned pos);
    hof_ring_t r;
    r = hof_ring_t'(1) << pos;
    return r;
  endfunction

  // Move a one-hot code to the next stage, wrapping from the top stage to 0.
  function automatic hof_ring_t hof_rotate(input hof_ring_t r);
    return {r[HOF_DEPTH-2:0], r[HOF_DEPTH-1]};
  endfunction

endpackage

// File: rtl/hof_ring.sv
module hof_ring
  import hof_pkg::*;
#(
  parameter int unsigned START = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  output hof_ring_t ptr
);

  localparam hof_ring_t RST_CODE = hof_onehot(START);

  hof_ring_t ring_d;
  hof_ring_t ring_q;

  // Next state: advance one stage on every clock.
  always_comb begin
    ring_d = hof_rotate(ring_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_q <= RST_CODE;
    end else begin
      ring_q <= ring_d;
    end
  end

  assign ptr = ring_q;

endmodule

// File: rtl/hof_stage.sv
module hof_stage #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] word_d;
  logic [WIDTH-1:0] word_q;

  // The enable stands in for a per-stage clock gate: the word only moves when opened.
  always_comb begin
    word_d = word_q;
    if (en) begin
      word_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign q = word_q;

endmodule

// File: rtl/hof_rdmux.sv
module hof_rdmux
  import hof_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  hof_ring_t                  sel,
  input  logic [HOF_DEPTH*WIDTH-1:0] stages,
  output logic [WIDTH-1:0]           q
);

  logic [WIDTH-1:0] pick;
  logic [WIDTH-1:0] out_q;

  // AND-OR select driven by the one-hot read ring.
  always_comb begin
    pick = '0;
    for (int i = 0; i < HOF_DEPTH; i++) begin
      pick = pick | (stages[i*WIDTH +: WIDTH] & {WIDTH{sel[i]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= pick;
    end
  end

  assign q = out_q;

endmodule

// File: rtl/hof_handoff.sv
module hof_handoff
  import hof_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  output logic [WIDTH-1:0] rd_data
);

  localparam int FLAT_W = HOF_DEPTH * WIDTH;

  hof_ring_t         wr_ptr;
  hof_ring_t         rd_ptr;
  logic [FLAT_W-1:0] stage_flat;

  // Write side: ring pointer, one gated stage per ring position.
  hof_ring #(.START(HOF_WR_START)) u_wr_ring (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .ptr   (wr_ptr)
  );

  for (genvar g = 0; g < HOF_DEPTH; g++) begin : g_stage
    hof_stage #(.WIDTH(WIDTH)) u_stage (
      .clk   (wr_clk),
      .rst_n (wr_rst_n),
      .en    (wr_ptr[g]),
      .d     (wr_data),
      .q     (stage_flat[g*WIDTH +: WIDTH])
    );
  end

  // Read side: independent ring, reset one stage behind the writer.
  hof_ring #(.START(HOF_RD_START)) u_rd_ring (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .ptr   (rd_ptr)
  );

  hof_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .clk    (rd_clk),
    .rst_n  (rd_rst_n),
    .sel    (rd_ptr),
    .stages (stage_flat),
    .q      (rd_data)
  );

endmodule

// File: rtl/hof_checker.sv
module hof_checker
  import hof_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input logic                       wr_clk,
  input logic                       wr_rst_n,
  input logic                       rd_clk,
  input logic                       rd_rst_n,
  input hof_ring_t                  wr_ptr,
  input hof_ring_t                  rd_ptr,
  input logic [HOF_DEPTH*WIDTH-1:0] stage_flat,
  input logic [WIDTH-1:0]           rd_data
);

  logic                       wr_seen;
  logic                       rd_seen;
  logic [HOF_DEPTH*WIDTH-1:0] stage_prev;
  hof_ring_t                  chg;
  logic [WIDTH-1:0]           sel_word;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wr_seen    <= 1'b0;
      stage_prev <= '0;
    end else begin
      wr_seen    <= 1'b1;
      stage_prev <= stage_flat;
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_seen <= 1'b0;
    end else begin
      rd_seen <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < HOF_DEPTH; i++) begin
      chg[i] = (stage_flat[i*WIDTH +: WIDTH] != stage_prev[i*WIDTH +: WIDTH]);
    end
  end

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < HOF_DEPTH; i++) begin
      if (rd_ptr[i]) begin
        sel_word = stage_flat[i*WIDTH +: WIDTH];
      end
    end
  end

  // R1: output and read ring held at their reset values while read reset is low
  always @(negedge rd_clk) begin
    if (rd_rst_n === 1'b0) begin
      a_r1_out_zero: assert (rd_data == '0)
        else $error("output not cleared in read reset");
      a_r3_rd_reset_pos: assert (rd_ptr == hof_onehot(HOF_RD_START))
        else $error("read ring not at its reset stage");
    end
  end

  // R2: write ring held at stage 0 during write reset
  always @(negedge wr_clk) begin
    if (wr_rst_n === 1'b0) begin
      a_r2_wr_reset_pos: assert (wr_ptr == hof_onehot(HOF_WR_START))
        else $error("write ring not at its reset stage");
    end
  end

  // R2: exactly one stage enabled at a time
  a_r2_wr_onehot: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_ptr) == 1);

  // R3: exactly one stage selected at a time
  a_r3_rd_onehot: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_ptr) == 1);

  // R6: at most one stage changes per write clock
  a_r6_single_stage: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_seen |-> $countones(chg) <= 1);

  // R6: a stage that changes is the one the write ring pointed at
  a_r6_only_pointed: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_seen |-> (chg & ~$past(wr_ptr)) == '0);

  // R4: output holds the stage selected on the previous read edge
  a_r4_out_loads: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_seen |-> rd_data == $past(sel_word));

endmodule

bind hof_handoff hof_checker #(.WIDTH(WIDTH)) u_hof_checker (
  .wr_clk     (wr_clk),
  .wr_rst_n   (wr_rst_n),
  .rd_clk     (rd_clk),
  .rd_rst_n   (rd_rst_n),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr),
  .stage_flat (stage_flat),
  .rd_data    (rd_data)
);

// File: tb/tb_hof_handoff.sv
`timescale 1ns/1ps
module tb_hof_handoff;

  localparam int W     = 12;
  localparam int NVEC  = 20;
  localparam int LOGSZ = 128;

  // Stimulus table; the expected output for read j is entry j-1 (zero for read 0).
  localparam logic [W-1:0] VEC [NVEC] = '{
    12'h001, 12'h002, 12'h003, 12'h004, 12'h005, 12'h006,
    12'h000, 12'hFFF, 12'hAAA, 12'h555, 12'hF0F, 12'h0F0,
    12'h123, 12'h456, 12'h789, 12'hABC, 12'hDEF, 12'h800,
    12'h7FF, 12'h3C5
  };

  logic         wr_clk;
  logic         rd_clk;
  logic         wr_rst_n;
  logic         rd_rst_n;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;

  int           checks;
  int           fails;
  int           nw;
  int           nr;
  bit           mon_en;
  int unsigned  ofs;
  logic [W-1:0] words [LOGSZ];

  hof_handoff #(.WIDTH(W)) dut (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_data  (wr_data),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_data  (rd_data)
  );

  // 100 MHz write clock
  initial begin
    wr_clk = 1'b0;
    forever #5 wr_clk = ~wr_clk;
  end

  // 100 MHz read clock with a random phase offset of 1..9 ns
  initial begin
    rd_clk = 1'b0;
    ofs = 1 + ($urandom % 9);
    #(ofs);
    forever #5 rd_clk = ~rd_clk;
  end

  task automatic check_eq(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Log every word taken by a write edge out of reset.
  always @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      nw <= 0;
    end else begin
      if (nw < LOGSZ) words[nw] <= wr_data;
      nw <= nw + 1;
    end
  end

  // Count read edges out of reset.
  always @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) nr <= 0;
    else           nr <= nr + 1;
  end

  // After read edge j (nr = j+1): expect zero for j = 0, else the word of write j-1.
  always @(negedge rd_clk) begin
    if (mon_en && rd_rst_n && nr >= 1) begin
      if (nr == 1)
        check_eq(rd_data, '0, "R5 R3 first read returns reset stage");
      else if (nr - 2 < nw && nr - 2 < LOGSZ)
        check_eq(rd_data, words[nr-2],
                 "R5 one-word delay (order R2 R3, load R4, one stage R6, bits R7)");
    end
  end

  task automatic run_stream(input int first, input int count);
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    mon_en   = 1'b0;
    wr_data  = '0;
    repeat (4) @(negedge wr_clk);
    check_eq(rd_data, '0, "R1 output zero while held in reset");
    @(negedge wr_clk);
    wr_data  = VEC[first];
    wr_rst_n = 1'b1;
    fork
      begin
        @(posedge wr_clk);
        @(negedge rd_clk);
        rd_rst_n = 1'b1;
      end
    join_none
    mon_en = 1'b1;
    for (int k = 1; k < count; k++) begin
      @(negedge wr_clk);
      wr_data = VEC[first + k];
    end
    repeat (4) @(negedge wr_clk);
    mon_en = 1'b0;
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    mon_en   = 1'b0;
    wr_rst_n = 1'b0;
    rd_rst_n = 1'b0;
    wr_data  = '0;
    fork
      begin : main_flow
        // Full table: several laps of the ring with distinct words and bit patterns.
        run_stream(0, NVEC);
        check_eq(rd_data, VEC[NVEC-1], "R7 last word held at output");

        // R1: asynchronous clear between clock edges
        @(negedge rd_clk);
        #2;
        rd_rst_n = 1'b0;
        #1;
        check_eq(rd_data, '0, "R1 output clears on read reset without a clock");

        // Restart from reset: rings return to their reset stages (R2, R3).
        run_stream(6, 8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
      begin : watchdog
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_any
  end

endmodule